// File: doc/BRIEF.md
# Eight-Pin GPIO Port with Peripheral Pin Ownership

This block is an 8-bit bidirectional general-purpose I/O port on a simple register bus. Software sets each pin's output value, its direction and its pullup through three registers. It reads the pins back through the value register. The block drives three per-pin controls toward the pad ring: output value, output enable and pullup enable.

Two peripherals can take over pins. While the SPI enable input is high, the SPI owns the four low pins. Each of the four high pins belongs to one timer channel, and that channel owns its pin while its two-bit edge/level select field is nonzero. An owned pin takes its output value and output enable from the peripheral inputs, and its pullup is held off. Register contents stay as written and apply again once ownership is released. The SPI and timer logic are outside this block. Only their enable, select and drive signals enter it.

Top module: `gpio_mux_port`

## Requirements
- R1: The register map uses `bus_addr` as follows: 0 is the value latch, 1 is direction and 2 is pullup. A write happens when `bus_sel` and `bus_wr` are high on a rising clock edge. Address 3 reads as zero, and writes to it change nothing.
- R2: After reset, the direction and pullup registers read zero. Every pin that no peripheral owns then has `pad_oe` and `pad_pu` low.
- R3: Reset does not change the value latch. A value written before a reset reappears on `pad_out` once the pin is made an output after the reset.
- R4: On a pin that no peripheral owns, direction bit 1 means output. `pad_oe` equals that direction bit and `pad_out` equals the latch bit. A register write shows at the outputs from the clock edge that performs it.
- R5: `pad_pu` is high only when the pin's pullup bit is 1, the pin is an input, and no peripheral owns it.
- R6: While `spi_en` is high, pins 0 to 3 take `pad_out` and `pad_oe` from `per_out` and `per_oe`, and their `pad_pu` is low.
- R7: Pin 4+k (k = 0..3) is owned by the timer channel whose select field is `tmr_sel[2k+1:2k]`, whenever that field is nonzero. The channel order is timer 1 channel 0, timer 1 channel 1, timer 2 channel 0, then timer 2 channel 1. An owned high pin behaves as in R6.
- R8: A read of address 0 returns the latch bit for unowned output pins. For input pins and owned pins it returns the pad level after a two-flop synchroniser, so a pad change is seen on the second rising edge after it.
- R9: The direction and pullup registers read back exactly as written, whether or not any pin is owned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| spi_en | input | 1 | SPI claims pins 0 to 3 |
| tmr_sel | input | 8 | Four 2-bit timer edge/level select fields, pins 4 to 7 |
| per_out | input | 8 | Peripheral output value per pin |
| per_oe | input | 8 | Peripheral output enable per pin |
| pad_in | input | 8 | Asynchronous pad levels |
| pad_out | output | 8 | Output value to pads |
| pad_oe | output | 8 | Output enable to pads |
| pad_pu | output | 8 | Pullup enable to pads |

## Verification
The bench sweeps all 256 direction values, all 256 pullup values, and all 512 combinations of SPI enable and timer select. Each step is compared with a bench-side model. A design that decoded a select field with AND instead of OR would release pins whose field is 01 or 10. A design that left pullups on for owned or output pins would fail the pullup sweep.

Mixed readback is tested with some pins latched and some pins live. A design that returned the latch for owned pins would report stale values. A design with one synchroniser flop too few or too many would fail the edge-counted latency check. A reset in the middle of the run exposes a design that clears the value latch, because stale data would no longer reappear. Writes to the unused address are checked against all three registers.

// File: rtl/gpio_mux_port.sv
`timescale 1ns/1ps
module gpio_mux_port (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_sel,
  input  logic       bus_wr,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       spi_en,
  input  logic [7:0] tmr_sel,
  input  logic [7:0] per_out,
  input  logic [7:0] per_oe,
  input  logic [7:0] pad_in,
  output logic [7:0] pad_out,
  output logic [7:0] pad_oe,
  output logic [7:0] pad_pu
);
  localparam logic [1:0] ADDR_VAL = 2'd0;
  localparam logic [1:0] ADDR_DIR = 2'd1;
  localparam logic [1:0] ADDR_PU  = 2'd2;

  logic [7:0] val_q, dir_q, pu_q;
  logic [7:0] meta_q, sync_q;
  logic [7:0] owned, live;
  logic       wr_en;

  assign wr_en = bus_sel & bus_wr;

  always_ff @(posedge clk)
    if (wr_en && bus_addr == ADDR_VAL) val_q <= bus_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dir_q <= '0;
      pu_q  <= '0;
    end else if (wr_en) begin
      if (bus_addr == ADDR_DIR) dir_q <= bus_wdata;
      if (bus_addr == ADDR_PU)  pu_q  <= bus_wdata;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= pad_in;
      sync_q <= meta_q;
    end

  assign owned[3:0] = {4{spi_en}};
  for (genvar k = 0; k < 4; k++) begin : g_tmr
    assign owned[4+k] = |tmr_sel[2*k+1:2*k];
  end

  assign pad_out = (per_out & owned) | (val_q & ~owned);
  assign pad_oe  = (per_oe  & owned) | (dir_q & ~owned);
  assign pad_pu  = pu_q & ~dir_q & ~owned;

  assign live = ~dir_q | owned;

  always_comb
    case (bus_addr)
      ADDR_VAL: bus_rdata = (val_q & ~live) | (sync_q & live);
      ADDR_DIR: bus_rdata = dir_q;
      ADDR_PU:  bus_rdata = pu_q;
      default:  bus_rdata = '0;
    endcase
endmodule

// File: rtl/gpio_mux_port_checker.sv
`timescale 1ns/1ps
module gpio_mux_port_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_sel,
  input logic       bus_wr,
  input logic [1:0] bus_addr,
  input logic [7:0] bus_wdata,
  input logic [7:0] bus_rdata,
  input logic       spi_en,
  input logic [7:0] tmr_sel,
  input logic [7:0] per_out,
  input logic [7:0] per_oe,
  input logic [7:0] pad_in,
  input logic [7:0] pad_out,
  input logic [7:0] pad_oe,
  input logic [7:0] pad_pu
);
  logic [1:0] since_rst;
  logic [7:0] own;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;

  assign own = {|tmr_sel[7:6], |tmr_sel[5:4], |tmr_sel[3:2], |tmr_sel[1:0], {4{spi_en}}};

  assert_spi_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    spi_en |-> (pad_out[3:0] == per_out[3:0] && pad_oe[3:0] == per_oe[3:0] && pad_pu[3:0] == 4'd0));

  assert_pu_inputs_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu & pad_oe) == 8'd0);

  assert_tmr_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe[7:4] ^ per_oe[7:4]) & own[7:4]) == 4'd0);

  assert_dir_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == 2'd1) |=> ((pad_oe & ~own) == ($past(bus_wdata) & ~own)));

  assert_sync_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd2 && bus_addr == 2'd0 && spi_en) |-> (bus_rdata[3:0] == $past(pad_in[3:0], 2)));

  assert_unused_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd3) |-> (bus_rdata == 8'd0));
endmodule

bind gpio_mux_port gpio_mux_port_checker u_chk (.*);

// File: tb/gpio_mux_port_bench.sv
`timescale 1ns/1ps
module gpio_mux_port_bench;
  logic       clk = 0, rst_n = 0;
  logic       bus_sel = 0, bus_wr = 0;
  logic [1:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic       spi_en = 0;
  logic [7:0] tmr_sel = 0, per_out = 0, per_oe = 0, pad_in = 0;
  logic [7:0] pad_out, pad_oe, pad_pu;

  int n_cmp = 0, n_bad = 0;
  logic done = 0;
  logic [7:0] m_val, m_dir, m_pu;

  always #5 clk = ~clk;

  gpio_mux_port u_gpio_mux_port (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
    case (a)
      2'd0: m_val = d;
      2'd1: m_dir = d;
      2'd2: m_pu  = d;
      default: ;
    endcase
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  function automatic logic [7:0] own_of(input logic s, input logic [7:0] t);
    logic [7:0] o;
    o[3:0] = s ? 4'hF : 4'h0;
    for (int k = 0; k < 4; k++) o[4+k] = (t[2*k +: 2] != 2'b00);
    return o;
  endfunction

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    logic [7:0] r, o, lv;
    m_val = 0; m_dir = 0; m_pu = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R2 reset state
    chk("R2 oe", pad_oe, 8'h00);
    chk("R2 pu", pad_pu, 8'h00);
    rd(2'd1, r); chk("R2 dir", r, 8'h00);
    rd(2'd2, r); chk("R2 pu reg", r, 8'h00);
    rd(2'd3, r); chk("R1 addr3", r, 8'h00);

    // R4 R9 R1 R8 direction sweep
    pad_in = 8'hC3;
    wr(2'd0, 8'h5A);
    repeat (2) @(negedge clk);
    for (int d = 0; d < 256; d++) begin
      wr(2'd1, d[7:0]);
      chk("R4 oe", pad_oe, m_dir);
      chk("R4 out", pad_out, m_val);
      rd(2'd1, r); chk("R9 dir", r, m_dir);
      rd(2'd0, r); chk("R8 mix", r, (m_val & m_dir) | (pad_in & ~m_dir));
    end

    // R5 pullup sweep
    wr(2'd1, 8'h0F);
    for (int p = 0; p < 256; p++) begin
      wr(2'd2, p[7:0]);
      chk("R5 pu", pad_pu, m_pu & ~m_dir);
      rd(2'd2, r); chk("R9 pu", r, m_pu);
    end

    // R6 R7 ownership sweep
    wr(2'd1, 8'h33); wr(2'd2, 8'hFF); wr(2'd0, 8'h96);
    per_out = 8'h5A; per_oe = 8'hC3;
    for (int s = 0; s < 2; s++)
      for (int t = 0; t < 256; t++) begin
        @(negedge clk);
        spi_en = s[0]; tmr_sel = t[7:0];
        o = own_of(s[0], t[7:0]);
        #1;
        chk(s[0] ? "R6 out" : "R7 out", pad_out, (per_out & o) | (m_val & ~o));
        chk(s[0] ? "R6 oe" : "R7 oe", pad_oe, (per_oe & o) | (m_dir & ~o));
        chk(s[0] ? "R6 pu" : "R7 pu", pad_pu, m_pu & ~m_dir & ~o);
        lv = ~m_dir | o;
        rd(2'd0, r); chk("R8 owned rd", r, (m_val & ~lv) | (pad_in & lv));
      end
    @(negedge clk); spi_en = 0; tmr_sel = 0;

    // R8 synchroniser latency
    wr(2'd1, 8'h00);
    bus_addr = 2'd0;
    @(negedge clk); pad_in = 8'h3C;
    @(negedge clk); rd(2'd0, r); chk("R8 lat1", r, 8'hC3);
    @(negedge clk); rd(2'd0, r); chk("R8 lat2", r, 8'h3C);

    // R1 unused address write ignored
    wr(2'd1, 8'hF0); wr(2'd2, 8'h0F); wr(2'd0, 8'hA5);
    wr(2'd3, 8'hFF);
    rd(2'd1, r); chk("R1 dir kept", r, 8'hF0);
    rd(2'd2, r); chk("R1 pu kept", r, 8'h0F);
    chk("R1 out kept", pad_out, 8'hA5);
    chk("R1 pu pins", pad_pu, 8'h0F);

    // R3 latch survives reset
    @(negedge clk); rst_n = 0;
    @(negedge clk); #1;
    chk("R2 oe in reset", pad_oe, 8'h00);
    @(negedge clk); rst_n = 1;
    m_dir = 0; m_pu = 0;
    wr(2'd1, 8'hFF);
    chk("R3 latch kept", pad_out, 8'hA5);
    rd(2'd0, r); chk("R3 readback", r, 8'hA5);

    done = 1;
    finish_run();
  end
endmodule